// File: doc/BRIEF.md
# Little-Endian Address Munging Unit

This unit sits between a load/store pipeline and a 64-bit memory or I/O bus. It lets the core run in either byte order without swapping data on ordinary accesses. In big-endian mode the effective address goes to the bus unchanged. In little-endian mode the three least significant address bits are XORed with a mask that depends on the access size. Byte enables are derived from the resulting address. For wide I/O transfers a separate path reverses the bytes of the whole doubleword. This makes a device see the same byte order that a series of single-byte accesses would produce.

A request carries the mode, an I/O flag, an instruction-fetch flag, the address, the size and the store data. One cycle later the unit presents the bus address, the byte enables and the lane-aligned write data with a valid flag. If the access is not naturally aligned, it presents an alignment-error pulse instead. Read data coming back from the bus is realigned using the context of the most recently issued request. It is shifted down to the least significant bits, zero-extended, and presented one cycle later.

Top module: `le_munge_unit`

## Requirements
- R1: In big-endian mode (`le_mode_i`=0) the bus address equals the request address in every bit.
- R2: In little-endian mode a byte access (`size_i`=0) XORs address bits [2:0] with 3'b111 and leaves the upper bits unchanged.
- R3: In little-endian mode a halfword (`size_i`=1) XORs bits [2:0] with 3'b110, a word (`size_i`=2) with 3'b100, and a doubleword (`size_i`=3) leaves them unchanged.
- R4: When `ifetch_i` is high the access is treated as a word (4 bytes) whatever `size_i` holds, including the word address modification in little-endian mode.
- R5: Byte enable bit k selects lane k (bus bits [8k+7:8k]). The enables are 1, 2, 4 or 8 consecutive ones starting at the lane given by bus address bits [2:0].
- R6: Write data on the bus is the low 1/2/4/8 bytes of `wdata_i`, shifted up by 8 times bus address bits [2:0]. All other lanes are zero, and bytes of `wdata_i` above the access size have no effect.
- R7: A request whose address bits [2:0] are not a multiple of the access size in bytes raises `align_err_o` for one cycle, and `bus_valid_o` stays low.
- R8: With `io_mode_i`=1 in little-endian mode, both the write data and the byte enables are byte-reversed (lane k to lane 7-k) after steering. In big-endian mode `io_mode_i` has no effect.
- R9: On a response (`rsp_valid_i`), `rdata_o` is formed in three steps. First, `rdata_i` is byte-reversed if the last issued request used the R8 reversal. Then it is shifted down by 8 times that request's bus address bits [2:0]. Finally it is cut to that request's size and zero-extended to 64 bits.
- R10: `bus_valid_o`, `bus_addr_o`, `bus_be_o`, `bus_wdata_o` and `align_err_o` appear one clock after a request; `rdata_o` and `rsp_valid_o` appear one clock after a response. Without a request or response the matching flags are low.
- R11: During reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| le_mode_i | input | 1 | 1 = little-endian mode |
| io_mode_i | input | 1 | 1 = I/O transfer (whole-doubleword reversal in little-endian mode) |
| ifetch_i | input | 1 | 1 = instruction fetch, forces word size |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| addr_i | input | ADDR_W | Effective address |
| wdata_i | input | 64 | Store operand, least significant bytes used |
| rsp_valid_i | input | 1 | Bus read data strobe |
| rdata_i | input | 64 | Bus read data, lane k at bits [8k+7:8k] |
| bus_valid_o | output | 1 | Bus request valid |
| bus_addr_o | output | ADDR_W | Modified bus address |
| bus_be_o | output | 8 | Byte enables, bit k for lane k |
| bus_wdata_o | output | 64 | Lane-aligned write data |
| align_err_o | output | 1 | Misaligned request pulse |
| rsp_valid_o | output | 1 | Realigned read data valid |
| rdata_o | output | 64 | Realigned, zero-extended read data |

## Verification
Every request result (bus valid, address, enables, write data, alignment error) is due exactly one rising edge after the request is presented. Every read result is due one edge after its response is presented. The bench drives inputs on the falling edge and compares on the next falling edge, so each comparison falls half a period after the single register stage. The sweep covers both modes, both I/O settings, instruction fetch on and off, all four sizes and all eight low-address offsets. Each aligned request is followed by a response cycle whose expected data uses that request's own context. That same cycle checks that no bus request follows an idle input.

// File: rtl/le_munge_pkg.sv
package le_munge_pkg;

  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = 3;
  localparam int unsigned BUS_W  = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  function automatic logic [BUS_W-1:0] rev_lanes(input logic [BUS_W-1:0] d);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[8*k +: 8] = d[8*(LANES-1-k) +: 8];
    end
    return r;
  endfunction

  function automatic logic [LANES-1:0] rev_bits(input logic [LANES-1:0] d);
    logic [LANES-1:0] r;
    for (int k = 0; k < LANES; k++) begin
      r[k] = d[LANES-1-k];
    end
    return r;
  endfunction

  function automatic logic [BUS_W-1:0] size_keep(input acc_size_e s);
    logic [BUS_W-1:0] m;
    case (s)
      SZ_BYTE: m = {{(BUS_W-8){1'b0}}, 8'hFF};
      SZ_HALF: m = {{(BUS_W-16){1'b0}}, 16'hFFFF};
      SZ_WORD: m = {{(BUS_W-32){1'b0}}, 32'hFFFF_FFFF};
      default: m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/le_addr_xform.sv
module le_addr_xform
  import le_munge_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              le_mode_i,
  input  logic              ifetch_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [LANE_W-1:0] low_o,
  output acc_size_e         size_o,
  output logic              misalign_o
);

  logic [LANE_W-1:0] flip;
  logic [LANE_W-1:0] size_low;
  logic [LANES-1:0]  be_base;

  always_comb begin
    size_o = ifetch_i ? SZ_WORD : acc_size_e'(size_i);
    case (size_o)
      SZ_BYTE: begin flip = 3'b111; size_low = 3'b000; be_base = 8'h01; end
      SZ_HALF: begin flip = 3'b110; size_low = 3'b001; be_base = 8'h03; end
      SZ_WORD: begin flip = 3'b100; size_low = 3'b011; be_base = 8'h0F; end
      default: begin flip = 3'b000; size_low = 3'b111; be_base = 8'hFF; end
    endcase
    if (!le_mode_i) flip = '0;
    low_o      = addr_i[LANE_W-1:0] ^ flip;
    addr_o     = {addr_i[ADDR_W-1:LANE_W], low_o};
    misalign_o = |(addr_i[LANE_W-1:0] & size_low);
    be_o       = be_base << low_o;
  end

endmodule

// File: rtl/le_lane_steer.sv
module le_lane_steer
  import le_munge_pkg::*;
(
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [LANE_W-1:0] low_i,
  input  acc_size_e         size_i,
  input  logic              swap_i,
  output logic [BUS_W-1:0]  wdata_o,
  output logic [LANES-1:0]  be_o
);

  logic [BUS_W-1:0] placed;

  always_comb begin
    placed  = (wdata_i & size_keep(size_i)) << {low_i, 3'b000};
    wdata_o = swap_i ? rev_lanes(placed) : placed;
    be_o    = swap_i ? rev_bits(be_i) : be_i;
  end

endmodule

// File: rtl/le_read_align.sv
module le_read_align
  import le_munge_pkg::*;
(
  input  logic [BUS_W-1:0]  rdata_i,
  input  logic [LANE_W-1:0] low_i,
  input  acc_size_e         size_i,
  input  logic              swap_i,
  output logic [BUS_W-1:0]  rdata_o
);

  logic [BUS_W-1:0] ordered;

  always_comb begin
    ordered = swap_i ? rev_lanes(rdata_i) : rdata_i;
    rdata_o = (ordered >> {low_i, 3'b000}) & size_keep(size_i);
  end

endmodule

// File: rtl/le_munge_unit.sv
module le_munge_unit
  import le_munge_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              le_mode_i,
  input  logic              io_mode_i,
  input  logic              ifetch_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic              rsp_valid_i,
  input  logic [63:0]       rdata_i,
  output logic              bus_valid_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_be_o,
  output logic [63:0]       bus_wdata_o,
  output logic              align_err_o,
  output logic              rsp_valid_o,
  output logic [63:0]       rdata_o
);

  logic [ADDR_W-1:0] x_addr;
  logic [LANES-1:0]  x_be;
  logic [LANE_W-1:0] x_low;
  acc_size_e         x_size;
  logic              x_mis;
  logic              x_swap;
  logic [BUS_W-1:0]  s_wdata;
  logic [LANES-1:0]  s_be;
  logic [BUS_W-1:0]  r_data;

  logic [LANE_W-1:0] ctx_low_q;
  acc_size_e         ctx_size_q;
  logic              ctx_swap_q;

  logic bus_valid_d, align_err_d, issue_en;

  le_addr_xform #(.ADDR_W(ADDR_W)) u_xform (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .le_mode_i  (le_mode_i),
    .ifetch_i   (ifetch_i),
    .addr_o     (x_addr),
    .be_o       (x_be),
    .low_o      (x_low),
    .size_o     (x_size),
    .misalign_o (x_mis)
  );

  assign x_swap = le_mode_i & io_mode_i;

  le_lane_steer u_steer (
    .wdata_i (wdata_i),
    .be_i    (x_be),
    .low_i   (x_low),
    .size_i  (x_size),
    .swap_i  (x_swap),
    .wdata_o (s_wdata),
    .be_o    (s_be)
  );

  le_read_align u_ralign (
    .rdata_i (rdata_i),
    .low_i   (ctx_low_q),
    .size_i  (ctx_size_q),
    .swap_i  (ctx_swap_q),
    .rdata_o (r_data)
  );

  always_comb begin
    issue_en    = req_valid_i & ~x_mis;
    bus_valid_d = issue_en;
    align_err_d = req_valid_i & x_mis;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_valid_o <= 1'b0;
      align_err_o <= 1'b0;
      rsp_valid_o <= 1'b0;
    end else begin
      bus_valid_o <= bus_valid_d;
      align_err_o <= align_err_d;
      rsp_valid_o <= rsp_valid_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr_o  <= '0;
      bus_be_o    <= '0;
      bus_wdata_o <= '0;
      ctx_low_q   <= '0;
      ctx_size_q  <= SZ_BYTE;
      ctx_swap_q  <= 1'b0;
    end else if (issue_en) begin
      bus_addr_o  <= x_addr;
      bus_be_o    <= s_be;
      bus_wdata_o <= s_wdata;
      ctx_low_q   <= x_low;
      ctx_size_q  <= x_size;
      ctx_swap_q  <= x_swap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (rsp_valid_i) begin
      rdata_o <= r_data;
    end
  end

  // R10: a bus request only follows a request one cycle earlier
  p_req_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> $past(req_valid_i));

  // R10: read data only follows a response one cycle earlier
  p_rsp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(rsp_valid_i));

  // R7: an alignment error never comes with a bus request
  p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_o |-> !bus_valid_o);

  // R5: the enables of a request form a block of 1, 2, 4 or 8 lanes
  p_be_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid_o |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                     $countones(bus_be_o) == 4 || $countones(bus_be_o) == 8));

  // R1: big-endian requests pass the address unchanged
  p_be_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && $past(!le_mode_i)) |-> bus_addr_o == $past(addr_i));

  // R2: a little-endian byte access flips all three low bits
  p_le_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && $past(le_mode_i && !ifetch_i && size_i == 2'd0))
      |-> bus_addr_o[2:0] == ($past(addr_i[2:0]) ^ 3'b111));

endmodule

// File: tb/le_munge_unit_tb.sv
module le_munge_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid_i, le_mode_i, io_mode_i, ifetch_i, rsp_valid_i;
  logic [1:0]    size_i;
  logic [AW-1:0] addr_i;
  logic [63:0]   wdata_i, rdata_i;
  logic          bus_valid_o, align_err_o, rsp_valid_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_be_o;
  logic [63:0]   bus_wdata_o, rdata_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  le_munge_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .le_mode_i(le_mode_i),
    .io_mode_i(io_mode_i), .ifetch_i(ifetch_i), .size_i(size_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rsp_valid_i(rsp_valid_i), .rdata_i(rdata_i),
    .bus_valid_o(bus_valid_o), .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o),
    .bus_wdata_o(bus_wdata_o), .align_err_o(align_err_o),
    .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] swap64(input logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [7:0] swap8(input logic [7:0] d);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = d[7-k];
    return r;
  endfunction

  function automatic logic [63:0] keep(input int nbytes);
    return (nbytes == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*nbytes)) - 64'd1);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0; le_mode_i = 1'b0; io_mode_i = 1'b0; ifetch_i = 1'b0;
    rsp_valid_i = 1'b0; size_i = 2'd0; addr_i = '0; wdata_i = '0; rdata_i = '0;
    repeat (3) @(negedge clk);
    // R11: outputs are zero while reset is held
    check("R11 bus_valid", {63'd0, bus_valid_o}, 64'd0);
    check("R11 align_err", {63'd0, align_err_o}, 64'd0);
    check("R11 rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
    check("R11 bus_be", {56'd0, bus_be_o}, 64'd0);
    check("R11 rdata", rdata_o, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int le = 0; le < 2; le++) begin
      for (int io = 0; io < 2; io++) begin
        for (int fe = 0; fe < 2; fe++) begin
          for (int sz = 0; sz < 4; sz++) begin
            for (int lo = 0; lo < 8; lo++) begin
              int esz, nb, fl, mlow, idx;
              logic mis, swp;
              logic [AW-1:0] a, ea;
              logic [63:0] w, r, ew, er;
              logic [7:0] ebe;
              idx  = ((le*2 + io)*2 + fe)*32 + sz*8 + lo;
              a    = {29'(idx*37 + 5), 3'(lo)};
              w    = 64'h0123_4567_89AB_CDEF ^ {8{8'(idx)}};
              r    = 64'hF0E1_D2C3_B4A5_9687 + 64'(idx * 64'h0001_0203_0405);
              esz  = fe ? 2 : sz;
              nb   = 1 << esz;
              // R2 R3 R4: little-endian flip masks per size
              fl   = (le == 0) ? 0 : (esz == 0 ? 7 : esz == 1 ? 6 : esz == 2 ? 4 : 0);
              mis  = (lo % nb) != 0;
              mlow = lo ^ fl;
              swp  = (le == 1) && (io == 1);
              ea   = {a[AW-1:3], 3'(mlow)};
              ebe  = 8'(((1 << nb) - 1) << mlow);
              ew   = (w & keep(nb)) << (8*mlow);
              if (swp) begin ebe = swap8(ebe); ew = swap64(ew); end
              er   = ((swp ? swap64(r) : r) >> (8*mlow)) & keep(nb);

              req_valid_i = 1'b1; le_mode_i = 1'(le); io_mode_i = 1'(io);
              ifetch_i = 1'(fe); size_i = 2'(sz); addr_i = a; wdata_i = w;
              @(negedge clk);
              req_valid_i = 1'b0;
              // R10: results one cycle after the request
              if (mis) begin
                check("R7 align_err", {63'd0, align_err_o}, 64'd1);
                check("R7 no bus_valid", {63'd0, bus_valid_o}, 64'd0);
              end else begin
                check("R7 no align_err", {63'd0, align_err_o}, 64'd0);
                check("R10 bus_valid", {63'd0, bus_valid_o}, 64'd1);
                if (le == 0) check("R1 addr", 64'(bus_addr_o), 64'(ea));
                else if (fe == 1) check("R4 addr", 64'(bus_addr_o), 64'(ea));
                else if (sz == 0) check("R2 addr", 64'(bus_addr_o), 64'(ea));
                else check("R3 addr", 64'(bus_addr_o), 64'(ea));
                check(swp ? "R8 be" : "R5 be", {56'd0, bus_be_o}, {56'd0, ebe});
                check(swp ? "R8 wdata" : "R6 wdata", bus_wdata_o, ew);
                rsp_valid_i = 1'b1; rdata_i = r;
                @(negedge clk);
                rsp_valid_i = 1'b0;
                check("R9 rdata", rdata_o, er);
                check("R10 rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
                check("R10 idle bus_valid", {63'd0, bus_valid_o}, 64'd0);
              end
            end
          end
        end
      end
    end
    @(negedge clk);
    check("R10 idle rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
    check("R10 idle align_err", {63'd0, align_err_o}, 64'd0);
    finish_run();
  end

endmodule